// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a processor into an asynchronous serial bit stream. A write strobe places the byte into a holding register. The holding register hands its byte to a shift register as soon as the shifter is free. Because there are two stages, the processor can write the next character while the current one is still on the line. Each frame starts with a low start bit. The data bits follow with the least significant bit first. An optional parity bit comes next, and a high stop period closes the frame. Outside a frame the line rests high.

The frame format is set by static configuration inputs: the character length, whether parity is used, the parity sense and the stop length. The format is captured when a character enters the shifter. Bit timing comes from a one-cycle tick pulse that arrives at sixteen times the baud rate. A break input drives the line low for as long as it is held. Two status outputs report progress. `hold_empty` is high when the holding register can take a byte. `line_empty` is high when both the holding register and the shifter are empty.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever no frame is in progress and break is low, `txd` is 1. Both `hold_empty` and `line_empty` are 1 after reset.
- R2: A frame begins with one start bit at 0, followed by the data bits least significant first. The number of data bits is set by `cfg_len`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R3: With `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_odd`=0 the parity bit makes the count of ones in data plus parity even. With `cfg_par_odd`=1 it makes that count odd. With `cfg_par_en`=0 no parity bit is sent.
- R4: The start bit, each data bit and the parity bit each last exactly 16 `baud_tick` pulses.
- R5: The stop period lasts 16 ticks when `cfg_two_stop`=0. With `cfg_two_stop`=1 it lasts 24 ticks for 5-bit characters and 32 ticks for 6-, 7- and 8-bit characters.
- R6: After a write strobe is sampled on a rising edge, `hold_empty` and `line_empty` stay unchanged by that write on that edge. Both are 0 after the following rising edge.
- R7: `hold_empty` returns to 1 when the held byte moves into the shifter. A byte written while a frame is shifting stays in the holding register and is sent immediately after the current stop period ends.
- R8: `line_empty` returns to 1 only after the last stop period has completed with the holding register empty. It stays 0 between back-to-back frames.
- R9: While `brk` is 1, `txd` is 0. When `brk` is released with no frame in progress, `txd` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | 8 | Character to send; unused upper bits ignored |
| cfg_len | input | 2 | Character length code (5 + value bits) |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | Long stop period (1.5 or 2 bits) |
| brk | input | 1 | Force the line low |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can accept a byte |
| line_empty | output | 1 | Holding register and shifter both empty |

## Verification
A wrong bit index or a bad shifter phase shows up on `txd` at the middle of the affected bit, at most 16 ticks after that bit starts. A wrong stop count moves the next falling edge of `txd`, or the rise of `line_empty`, by a whole number of half-bits, so it is seen when the frame closes. A fault in the holding stage shows on the status pins within two or three clock edges of a write. Such faults include an early or late flag drop, a lost pending byte, or a transfer made too early. A lost byte also leaves the scoreboard with an expected frame that never appears.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int DW = 8;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } phase_t;

  // Index of the final data bit for a length code (5..8 bits).
  function automatic logic [2:0] last_idx(input logic [1:0] len);
    return 3'd4 + {1'b0, len};
  endfunction

  // Stop period in ticks; the half-bit form only exists for 5-bit characters.
  function automatic int stop_span(input logic two, input logic [1:0] len, input int ovs);
    if (!two)          return ovs;
    else if (len == 0) return ovs + ovs / 2;
    else               return 2 * ovs;
  endfunction

  // Parity over the active data bits; seed of 1 yields odd parity.
  function automatic logic parity_of(input logic [DW-1:0] d, input logic [1:0] len,
                                     input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < DW; i++) begin
      if (i <= int'(last_idx(len))) p = p ^ d[i];
    end
    return p;
  endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
  import sertx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          sh_idle,
  output logic [DW-1:0] hold_q,
  output logic          xfer,
  output logic          hold_empty,
  output logic          line_empty
);

  logic wr_seen;    // write sampled on the previous edge
  logic hold_full;

  // Hand-over waits until the flag drop from a fresh write has happened.
  assign xfer = hold_full && !wr_seen && sh_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      wr_seen    <= 1'b0;
      hold_full  <= 1'b0;
      hold_empty <= 1'b1;
      line_empty <= 1'b1;
    end else begin
      wr_seen <= wr_stb;
      if (wr_stb) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end else if (xfer) begin
        hold_full <= 1'b0;
      end
      if (wr_seen)   hold_empty <= 1'b0;
      else if (xfer) hold_empty <= 1'b1;
      if (wr_seen)                      line_empty <= 1'b0;
      else if (sh_idle && !hold_full)   line_empty <= 1'b1;
    end
  end

  assert_flags_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> ##1 (!hold_empty && !line_empty));

  assert_first_edge_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && hold_empty && !wr_seen) |=> hold_empty);

  assert_empty_needs_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_empty) |-> $past(sh_idle));

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_two_stop,
  output logic          bit_o,
  output logic          idle,
  output logic          in_stop
);

  localparam int CW = $clog2(2 * OVS + 1);

  phase_t        ph;
  logic [CW-1:0] tcnt;
  logic [2:0]    bidx;
  logic [DW-1:0] sreg;
  logic [1:0]    len_q;
  logic          pen_q;
  logic          pbit_q;
  logic [CW-1:0] stop_q;

  logic bit_end, stop_end;
  assign bit_end  = tick && (tcnt == CW'(OVS - 1));
  assign stop_end = tick && (tcnt == stop_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      tcnt   <= '0;
      bidx   <= '0;
      sreg   <= '0;
      len_q  <= '0;
      pen_q  <= 1'b0;
      pbit_q <= 1'b0;
      stop_q <= CW'(OVS);
    end else if (load) begin
      ph     <= PH_START;
      tcnt   <= '0;
      bidx   <= '0;
      sreg   <= ld_data;
      len_q  <= cfg_len;
      pen_q  <= cfg_par_en;
      pbit_q <= parity_of(ld_data, cfg_len, cfg_par_odd);
      stop_q <= CW'(stop_span(cfg_two_stop, cfg_len, OVS));
    end else if (tick && ph != PH_IDLE) begin
      case (ph)
        PH_START: begin
          if (bit_end) begin
            ph   <= PH_DATA;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        end
        PH_DATA: begin
          if (bit_end) begin
            tcnt <= '0;
            sreg <= sreg >> 1;
            if (bidx == last_idx(len_q)) ph <= pen_q ? PH_PAR : PH_STOP;
            else                         bidx <= bidx + 1'b1;
          end else tcnt <= tcnt + 1'b1;
        end
        PH_PAR: begin
          if (bit_end) begin
            ph   <= PH_STOP;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        end
        PH_STOP: begin
          if (stop_end) begin
            ph   <= PH_IDLE;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    case (ph)
      PH_START: bit_o = 1'b0;
      PH_DATA:  bit_o = sreg[0];
      PH_PAR:   bit_o = pbit_q;
      default:  bit_o = 1'b1;
    endcase
  end

  assign idle    = (ph == PH_IDLE);
  assign in_stop = (ph == PH_STOP);

  assert_start_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !bit_o);

  assert_count_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(tcnt));

  assert_no_load_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> idle);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       brk,
  input  logic       baud_tick,
  output logic       txd,
  output logic       hold_empty,
  output logic       line_empty
);

  logic [DW-1:0] hold_q;
  logic          xfer;
  logic          sh_idle;
  logic          sh_bit;
  logic          sh_stop;

  sertx_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .sh_idle    (sh_idle),
    .hold_q     (hold_q),
    .xfer       (xfer),
    .hold_empty (hold_empty),
    .line_empty (line_empty)
  );

  sertx_shift #(.OVS(OVS)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (baud_tick),
    .load         (xfer),
    .ld_data      (hold_q),
    .cfg_len      (cfg_len),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_odd  (cfg_par_odd),
    .cfg_two_stop (cfg_two_stop),
    .bit_o        (sh_bit),
    .idle         (sh_idle),
    .in_stop      (sh_stop)
  );

  assign txd = brk ? 1'b0 : sh_bit;

  assert_break_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_idle && !brk) |-> txd);

  assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_stop && !brk) |-> txd);

  assert_busy_not_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_idle |-> !line_empty);

endmodule

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TPB        = 16;

  typedef struct {
    logic [7:0] data;
    int         nbits;
    logic       pen;
    logic       podd;
    int         stop_t;
  } frame_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_len = '0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       brk = 1'b0;
  logic       baud_tick = 1'b0;
  logic       txd, hold_empty, line_empty;

  int     n_chk = 0;
  int     n_bad = 0;
  int     ticks_seen = 0;
  int     div = 0;
  logic   mon_en = 1'b1;
  logic   prev_txd = 1'b1;
  frame_t expq[$];

  sertx_top #(.OVS(TPB)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .brk(brk), .baud_tick(baud_tick),
    .txd(txd), .hold_empty(hold_empty), .line_empty(line_empty)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    div = (div + 1) % 4;
    baud_tick = (div == 0);
  end

  always @(posedge clk) if (baud_tick) ticks_seen <= ticks_seen + 1;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_write(input logic [7:0] d);
    frame_t f;
    f.data   = d;
    f.nbits  = 5 + int'(cfg_len);
    f.pen    = cfg_par_en;
    f.podd   = cfg_par_odd;
    if (!cfg_two_stop)     f.stop_t = TPB;
    else if (f.nbits == 5) f.stop_t = TPB * 3 / 2;
    else                   f.stop_t = TPB * 2;
    expq.push_back(f);
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  // Write at idle and follow the status pins edge by edge.
  task automatic timed_write(input logic [7:0] d);
    push_write(d);
    chk(hold_empty == 1'b1, "R6 hold_empty first edge", hold_empty, 1);
    chk(line_empty == 1'b1, "R6 line_empty first edge", line_empty, 1);
    @(negedge clk);
    chk(hold_empty == 1'b0, "R6 hold_empty second edge", hold_empty, 0);
    chk(line_empty == 1'b0, "R6 line_empty second edge", line_empty, 0);
    @(negedge clk);
    chk(hold_empty == 1'b1, "R7 hold_empty after transfer", hold_empty, 1);
    chk(line_empty == 1'b0, "R8 line_empty while shifting", line_empty, 0);
  endtask

  task automatic wait_idle();
    while (!(line_empty && expq.size() == 0)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_frame(output logic again);
    frame_t f;
    int     t0, nb, ones, total;
    logic   expb;
    again = 1'b0;
    t0 = ticks_seen;
    if (expq.size() == 0) begin
      chk(1'b0, "R7 unexpected frame", 1, 0);
      return;
    end
    f = expq.pop_front();
    nb = 1 + f.nbits + (f.pen ? 1 : 0);
    ones = 0;
    for (int b = 0; b < nb; b++) begin
      while (ticks_seen - t0 != TPB * b + TPB / 2) @(negedge clk);
      if (b == 0) begin
        chk(txd == 1'b0, "R2 start bit", txd, 0);
      end else if (b <= f.nbits) begin
        expb = f.data[b-1];
        ones += int'(expb);
        chk(txd == expb, "R2 data bit", txd, expb);
      end else begin
        expb = f.podd ? ~ones[0] : ones[0];
        chk(txd == expb, "R3 parity bit", txd, expb);
      end
    end
    while (ticks_seen - t0 != TPB * nb + TPB / 2) @(negedge clk);
    chk(txd == 1'b1, "R5 stop level", txd, 1);
    while (txd != 1'b0 && !line_empty) @(negedge clk);
    total = TPB * nb + f.stop_t;
    chk(ticks_seen - t0 == total, "R4 R5 frame length in ticks", ticks_seen - t0, total);
    if (txd == 1'b0) again = 1'b1;
  endtask

  initial begin : monitor
    logic again;
    forever begin
      @(negedge clk);
      if (rst_n && mon_en && prev_txd && !txd) begin
        again = 1'b1;
        while (again) run_frame(again);
      end
      prev_txd = txd;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 txd in reset", txd, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd after reset", txd, 1);
    chk(hold_empty == 1'b1, "R1 hold_empty after reset", hold_empty, 1);
    chk(line_empty == 1'b1, "R1 line_empty after reset", line_empty, 1);

    cfg_len = 2'b00; cfg_par_en = 0; cfg_two_stop = 0;
    timed_write(8'h15);
    wait_idle();
    chk(txd == 1'b1, "R1 idle after frame", txd, 1);

    cfg_len = 2'b00; cfg_two_stop = 1;
    timed_write(8'hEA);
    wait_idle();

    cfg_len = 2'b01; cfg_par_en = 1; cfg_par_odd = 0; cfg_two_stop = 1;
    timed_write(8'h2D);
    wait_idle();

    cfg_len = 2'b10; cfg_par_en = 1; cfg_par_odd = 1; cfg_two_stop = 0;
    timed_write(8'h5A);
    wait_idle();

    cfg_len = 2'b11; cfg_par_en = 1; cfg_par_odd = 0; cfg_two_stop = 1;
    timed_write(8'hA7);
    wait_idle();

    // Back-to-back pair: the second byte waits in the holding register.
    cfg_len = 2'b11; cfg_par_en = 1; cfg_par_odd = 1; cfg_two_stop = 0;
    timed_write(8'h3C);
    repeat (20) @(negedge clk);
    push_write(8'hC3);
    @(negedge clk);
    chk(hold_empty == 1'b0, "R7 byte pending while shifting", hold_empty, 0);
    repeat (200) @(negedge clk);
    chk(hold_empty == 1'b0, "R7 still pending mid frame", hold_empty, 0);
    while (!hold_empty) @(negedge clk);
    chk(line_empty == 1'b0, "R8 no empty between frames", line_empty, 0);
    wait_idle();
    chk(line_empty == 1'b1, "R8 empty after last stop", line_empty, 1);

    mon_en = 1'b0;
    brk = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R9 break low", txd, 0);
    repeat (30) @(negedge clk);
    chk(txd == 1'b0, "R9 break held low", txd, 0);
    brk = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R9 line high after break", txd, 1);
    repeat (3) @(negedge clk);
    mon_en = 1'b1;

    chk(expq.size() == 0, "R7 all frames sent", expq.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule